// File: doc/BRIEF.md
# Cascadable TDM Voice-Sample Serial Port

This block is the digital half of a four-wire synchronous serial port for a voice codec. It runs as a slave to an external bit clock and frame strobe. Both arrive already synchronous to the block clock `clk`, which runs several times faster than the bit clock. Each frame opens when the frame strobe goes low. In its own time slot of sixteen bit clocks, the block sends one 16-bit two's-complement sample, most significant bit first, and receives one sample in the same way.

Once its slot has run, the block passes the frame timing down a daisy chain. It does this through an active-low delayed strobe, which the next device treats as its own frame start. A chain of up to `MAX_DEV` devices can share one port this way. A device-position input marks the last device in the chain, and that device emits no handoff. A loopback mode sends back the most recently received word as the next transmit word, in place of the parallel transmit sample.

Top module: `tdm_codec_port`

## Requirements
- R1: A frame starts when the frame strobe `fs_n_i` is sampled low at a falling bit-clock edge after being sampled high at the previous falling edge. The length of the low level has no effect. A falling strobe seen while a slot is still receiving, before its 16th bit, is ignored.
- R2: The 16 bits of the transmit word are launched on `dout_o` from 16 successive rising bit-clock edges, most significant bit first. The first of these edges is the first rising edge after the frame start. `dout_oe_o` goes high at the first of these edges and goes low at the next rising edge after the 16th.
- R3: `din_i` is sampled on the 16 falling bit-clock edges that follow the frame start, most significant bit first. Bits pass through unchanged in two's-complement form.
- R4: After the 16th falling edge of a slot, the received word appears on `rx_sample_o`, and `rx_valid_o` is high for exactly one `clk` cycle.
- R5: `fsd_n_o` goes low at the rising edge that launches the 16th bit and returns high at the following rising edge. This makes it low for exactly one bit-clock cycle, 16 bit clocks after the received frame start.
- R6: When `dev_pos_i` equals `MAX_DEV-1` (7 by default, the last device), `fsd_n_o` stays high. The data transfer is not affected.
- R7: When `loopback_i` is 1 at frame start, the word transmitted is the last received word instead of `tx_sample_i`.
- R8: A new frame start sampled at the same falling edge as the 16th data bit is accepted. Both words then transfer with `dout_oe_o` held high across the boundary.
- R9: While `rst` is high, and after it, `dout_oe_o`=0, `dout_o`=0, `fsd_n_o`=1, `rx_valid_o`=0 and `rx_sample_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial bit clock |
| fs_n_i | input | 1 | Frame strobe, falling edge starts a frame |
| din_i | input | 1 | Serial receive data |
| dout_o | output | 1 | Serial transmit data |
| dout_oe_o | output | 1 | High while `dout_o` must be driven onto the line |
| fsd_n_o | output | 1 | Delayed active-low strobe for the next device |
| tx_sample_i | input | WORD_W | Parallel sample to transmit |
| rx_sample_o | output | WORD_W | Last received sample |
| rx_valid_o | output | 1 | One-cycle strobe marking a new `rx_sample_o` |
| dev_pos_i | input | POS_W | Position of this device in the chain |
| loopback_i | input | 1 | Transmit the last received word instead of `tx_sample_i` |

## Verification
The bench holds the frame strobe low for several bit clocks. A design that treated the level as the trigger would restart the slot repeatedly. It also pulls the strobe low halfway through a slot, which a design without busy gating would obey by restarting the shift and corrupting both words. Back-to-back frames check for two faults: a design that still counts the slot as busy would drop the second frame, and one that released the output enable would leave a gap between the frames. Loopback frames check that the transmitted word is the previous received one, and a design using a stale or off-by-one register would show up there. The last-position case checks that no handoff strobe is emitted.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic fs_fall;
    } sclk_evt_t;

    function automatic int cnt_width(input int span);
        return (span < 2) ? 1 : $clog2(span);
    endfunction

endpackage

// File: rtl/tdm_sclk_edges.sv
module tdm_sclk_edges
    import tdm_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk_i,
    input  logic      fs_n_i,
    output sclk_evt_t evt_o
);

    logic sclk_q;
    logic fs_prev_q;

    always_comb begin
        evt_o.rise    = sclk_i & ~sclk_q;
        evt_o.fall    = ~sclk_i & sclk_q;
        evt_o.fs_fall = evt_o.fall & fs_prev_q & ~fs_n_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            fs_prev_q <= 1'b1;
        end else begin
            sclk_q <= sclk_i;
            if (evt_o.fall) begin
                fs_prev_q <= fs_n_i;
            end
        end
    end

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
    import tdm_port_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CW = cnt_width(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              din_i,
    output logic              busy_o,
    output logic              last_o,
    output logic [WORD_W-1:0] word_now_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);

    localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);

    logic [WORD_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;

    assign last_o     = busy_o && (cnt_q == LAST_IDX);
    assign word_now_o = {sh_q[WORD_W-2:0], din_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            busy_o     <= 1'b0;
            rx_word_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (fall_i) begin
                if (busy_o) begin
                    sh_q  <= word_now_o;
                    cnt_q <= cnt_q + 1'b1;
                    if (last_o) begin
                        rx_word_o  <= word_now_o;
                        rx_valid_o <= 1'b1;
                        busy_o     <= 1'b0;
                    end
                end
                if (start_i) begin
                    busy_o <= 1'b1;
                    cnt_q  <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
    import tdm_port_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int CW = cnt_width(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_word_i,
    input  logic              handoff_en_i,
    output logic              dout_o,
    output logic              oe_o,
    output logic              fsd_n_o
);

    localparam logic [CW-1:0] END_IDX     = CW'(WORD_W);
    localparam logic [CW-1:0] HANDOFF_IDX = CW'(WORD_W - 1);

    tx_state_e         state_q;
    logic [WORD_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            dout_o  <= 1'b0;
            oe_o    <= 1'b0;
            fsd_n_o <= 1'b1;
        end else if (load_i) begin
            state_q <= TX_ARMED;
            sh_q    <= load_word_i;
        end else if (rise_i) begin
            case (state_q)
                TX_ARMED: begin
                    dout_o  <= sh_q[WORD_W-1];
                    sh_q    <= sh_q << 1;
                    cnt_q   <= CW'(1);
                    oe_o    <= 1'b1;
                    fsd_n_o <= 1'b1;
                    state_q <= TX_SHIFT;
                end
                TX_SHIFT: begin
                    if (cnt_q == END_IDX) begin
                        dout_o  <= 1'b0;
                        oe_o    <= 1'b0;
                        fsd_n_o <= 1'b1;
                        state_q <= TX_IDLE;
                    end else begin
                        dout_o  <= sh_q[WORD_W-1];
                        sh_q    <= sh_q << 1;
                        cnt_q   <= cnt_q + 1'b1;
                        fsd_n_o <= ~(handoff_en_i && (cnt_q == HANDOFF_IDX));
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tdm_codec_port.sv
module tdm_codec_port
    import tdm_port_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int MAX_DEV = 8,
    parameter int POS_W   = cnt_width(MAX_DEV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              fs_n_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic              fsd_n_o,
    input  logic [WORD_W-1:0] tx_sample_i,
    output logic [WORD_W-1:0] rx_sample_o,
    output logic              rx_valid_o,
    input  logic [POS_W-1:0]  dev_pos_i,
    input  logic              loopback_i
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(MAX_DEV - 1);

    sclk_evt_t         evt;
    logic              rx_busy;
    logic              rx_last;
    logic [WORD_W-1:0] rx_word_now;
    logic              frame_start;
    logic [WORD_W-1:0] loop_word;
    logic [WORD_W-1:0] load_word;

    assign frame_start = evt.fs_fall && (!rx_busy || rx_last);
    assign loop_word   = rx_last ? rx_word_now : rx_sample_o;
    assign load_word   = loopback_i ? loop_word : tx_sample_i;

    tdm_sclk_edges edges_i (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .fs_n_i (fs_n_i),
        .evt_o  (evt)
    );

    tdm_rx_deser #(.WORD_W(WORD_W)) rx_i (
        .clk        (clk),
        .rst        (rst),
        .fall_i     (evt.fall),
        .start_i    (frame_start),
        .din_i      (din_i),
        .busy_o     (rx_busy),
        .last_o     (rx_last),
        .word_now_o (rx_word_now),
        .rx_word_o  (rx_sample_o),
        .rx_valid_o (rx_valid_o)
    );

    tdm_tx_ser #(.WORD_W(WORD_W)) tx_i (
        .clk          (clk),
        .rst          (rst),
        .rise_i       (evt.rise),
        .load_i       (frame_start),
        .load_word_i  (load_word),
        .handoff_en_i (dev_pos_i != LAST_POS),
        .dout_o       (dout_o),
        .oe_o         (dout_oe_o),
        .fsd_n_o      (fsd_n_o)
    );

endmodule

// File: rtl/tdm_codec_port_chk.sv
module tdm_codec_port_chk #(
    parameter int WORD_W  = 16,
    parameter int MAX_DEV = 8,
    parameter int POS_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              sclk_i,
    input logic              fs_n_i,
    input logic              din_i,
    input logic              dout_o,
    input logic              dout_oe_o,
    input logic              fsd_n_o,
    input logic [WORD_W-1:0] tx_sample_i,
    input logic [WORD_W-1:0] rx_sample_o,
    input logic              rx_valid_o,
    input logic [POS_W-1:0]  dev_pos_i,
    input logic              loopback_i
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(MAX_DEV - 1);

    a_r2_dout_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout_o) |-> $past(sclk_i));

    a_r2_oe_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout_oe_o) |-> $past(sclk_i));

    a_r5_fsd_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(fsd_n_o) |-> $past(sclk_i));

    a_r5_fsd_inside_slot: assert property (@(posedge clk) disable iff (rst)
        !fsd_n_o |-> dout_oe_o);

    a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    a_r4_valid_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid_o) |-> !$past(sclk_i));

    a_r6_no_handoff_last: assert property (@(posedge clk) disable iff (rst)
        $fell(fsd_n_o) |-> ($past(dev_pos_i) != LAST_POS));

endmodule

bind tdm_codec_port tdm_codec_port_chk #(
    .WORD_W  (WORD_W),
    .MAX_DEV (MAX_DEV),
    .POS_W   (POS_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sclk_i      (sclk_i),
    .fs_n_i      (fs_n_i),
    .din_i       (din_i),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o),
    .fsd_n_o     (fsd_n_o),
    .tx_sample_i (tx_sample_i),
    .rx_sample_o (rx_sample_o),
    .rx_valid_o  (rx_valid_o),
    .dev_pos_i   (dev_pos_i),
    .loopback_i  (loopback_i)
);

// File: tb/tdm_codec_port_tb_top.sv
module tdm_codec_port_tb_top;

    localparam int WORD_W  = 16;
    localparam int MAX_DEV = 8;
    localparam int POS_W   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sclk = 1'b0;
    logic              fs_n = 1'b1;
    logic              din = 1'b0;
    logic              dout_o;
    logic              dout_oe_o;
    logic              fsd_n_o;
    logic [WORD_W-1:0] tx_sample = '0;
    logic [WORD_W-1:0] rx_sample_o;
    logic              rx_valid_o;
    logic [POS_W-1:0]  dev_pos = 3'd2;
    logic              loopback = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] fs_v, din_v, dout_r, oe_r, fsd_r;
    int          vcnt = 0;
    logic [15:0] vwords [4];

    always #5 clk = ~clk;

    tdm_codec_port #(.WORD_W(WORD_W), .MAX_DEV(MAX_DEV), .POS_W(POS_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .sclk_i      (sclk),
        .fs_n_i      (fs_n),
        .din_i       (din),
        .dout_o      (dout_o),
        .dout_oe_o   (dout_oe_o),
        .fsd_n_o     (fsd_n_o),
        .tx_sample_i (tx_sample),
        .rx_sample_o (rx_sample_o),
        .rx_valid_o  (rx_valid_o),
        .dev_pos_i   (dev_pos),
        .loopback_i  (loopback)
    );

    always @(negedge clk) begin
        if (!rst && rx_valid_o) begin
            if (vcnt < 4) vwords[vcnt] = rx_sample_o;
            vcnt = vcnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_seq();
        fs_v   = '1;
        din_v  = '0;
        dout_r = '0;
        oe_r   = '0;
        fsd_r  = '1;
    endtask

    task automatic place_frame(input int base, input logic [15:0] w);
        fs_v[base] = 1'b0;
        for (int i = 0; i < 16; i++) din_v[base + 1 + i] = w[15 - i];
    endtask

    function automatic logic [15:0] got_word(input int base);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[15 - i] = dout_r[base + 1 + i];
        return r;
    endfunction

    function automatic logic [63:0] span(input int lo, input int hi);
        logic [63:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    task automatic run_seq(input int n);
        vcnt = 0;
        for (int c = 0; c < n; c++) begin
            sclk = 1'b1;
            fs_n = fs_v[c];
            din  = din_v[c];
            repeat (4) @(negedge clk);
            dout_r[c] = dout_o;
            oe_r[c]   = dout_oe_o;
            fsd_r[c]  = fsd_n_o;
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        fs_n = 1'b1;
    endtask

    task automatic t_reset();
        check(dout_oe_o == 1'b0, "R9 oe after reset", dout_oe_o, 0);
        check(fsd_n_o == 1'b1, "R9 fsd after reset", fsd_n_o, 1);
        check(rx_valid_o == 1'b0 && rx_sample_o == '0, "R9 rx after reset", rx_sample_o, 0);
        check(dout_o == 1'b0, "R9 dout after reset", dout_o, 0);
    endtask

    task automatic t_basic(input logic [15:0] txw, input logic [15:0] dw);
        clear_seq();
        tx_sample = txw;
        place_frame(2, dw);
        fs_v[3] = 1'b0;
        fs_v[4] = 1'b0;
        run_seq(24);
        check(got_word(2) == txw, "R2 dout word", got_word(2), txw);
        check(oe_r == span(3, 18), "R2 oe window", oe_r, span(3, 18));
        check(fsd_r == ~span(18, 18), "R5 fsd pulse", fsd_r, ~span(18, 18));
        check(vcnt == 1, "R4 one valid per slot", vcnt, 1);
        check(vwords[0] == dw, "R3 received word", vwords[0], dw);
        check(vcnt == 1, "R1 long low strobe starts one frame", vcnt, 1);
    endtask

    task automatic t_last_pos();
        dev_pos = 3'd7;
        clear_seq();
        tx_sample = 16'h6E21;
        place_frame(2, 16'h0BAD);
        run_seq(24);
        check(fsd_r == '1, "R6 no handoff at last position", fsd_r, 64'hFFFF_FFFF_FFFF_FFFF);
        check(got_word(2) == 16'h6E21, "R6 data unaffected", got_word(2), 16'h6E21);
        check(vwords[0] == 16'h0BAD, "R6 rx unaffected", vwords[0], 16'h0BAD);
        dev_pos = 3'd2;
    endtask

    task automatic t_fs_midslot();
        clear_seq();
        tx_sample = 16'hC0DE;
        place_frame(2, 16'h55AA);
        fs_v[10] = 1'b0;
        run_seq(30);
        check(vcnt == 1, "R1 mid-slot strobe ignored (valid count)", vcnt, 1);
        check(vwords[0] == 16'h55AA, "R1 mid-slot rx word", vwords[0], 16'h55AA);
        check(got_word(2) == 16'hC0DE, "R1 mid-slot tx word", got_word(2), 16'hC0DE);
        check(oe_r == span(3, 18), "R1 no restarted slot", oe_r, span(3, 18));
    endtask

    task automatic t_loopback();
        loopback = 1'b0;
        clear_seq();
        tx_sample = 16'h1111;
        place_frame(2, 16'h3C5A);
        run_seq(22);
        loopback = 1'b1;
        tx_sample = 16'h0F0F;
        clear_seq();
        place_frame(2, 16'h9876);
        run_seq(22);
        check(got_word(2) == 16'h3C5A, "R7 loopback first word", got_word(2), 16'h3C5A);
        check(vwords[0] == 16'h9876, "R3 rx during loopback", vwords[0], 16'h9876);
        clear_seq();
        place_frame(2, 16'h0000);
        run_seq(22);
        check(got_word(2) == 16'h9876, "R7 loopback second word", got_word(2), 16'h9876);
        loopback = 1'b0;
    endtask

    task automatic t_chain();
        clear_seq();
        tx_sample = 16'hA001;
        place_frame(2, 16'h8000);
        place_frame(18, 16'h7FFF);
        run_seq(40);
        check(oe_r == span(3, 34), "R8 oe continuous", oe_r, span(3, 34));
        check(got_word(2) == 16'hA001, "R8 first tx word", got_word(2), 16'hA001);
        check(got_word(18) == 16'hA001, "R8 second tx word", got_word(18), 16'hA001);
        check(vcnt == 2, "R8 two valid strobes", vcnt, 2);
        check(vwords[0] == 16'h8000 && vwords[1] == 16'h7FFF, "R8 rx words",
              {vwords[0], vwords[1]}, {16'h8000, 16'h7FFF});
        check(fsd_r == ~(span(18, 18) | span(34, 34)), "R5 fsd per slot",
              fsd_r, ~(span(18, 18) | span(34, 34)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic(16'hA5C3, 16'h1234);
        t_basic(16'h8001, 16'h7FFE);
        t_last_pos();
        t_fs_midslot();
        t_loopback();
        t_chain();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule